// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

This block is a control state machine that sits above an MDIO management master. On a start pulse it walks the 32 management addresses, reads each one's status register and decides from a fixed bit pattern whether a transceiver answers there. Each transceiver it accepts goes into a small address table. It then reads that transceiver's control and advertisement registers and programs both. The advertisement comes from the host if the host gives one, otherwise from the value kept for that table slot by an earlier scan, otherwise from what the transceiver itself reports.

The control register is rebuilt from the requested mode (autonegotiation or forced), duplex and speed. It is written back only when the new value differs from the value read. If the autonegotiation enable bit changes state, the same value is written twice, with a settling wait of a parameterised number of microseconds between the two writes. All register traffic goes through a request/acknowledge handshake to the MDIO master. The results are the address table, a count and a done level.

Top module: `phy_scan_seq`

## Requirements
- R1: After start, status register 1 is read at addresses 1, 2, …, 31 and then 0, in that order. Each probe is one read request with the write flag low.
- R2: An address is accepted when (status & 0x8301) == 0x8001, or when status bit 15 is 0 and (status & 0x7800) != 0. An all-ones answer is rejected. Accepted addresses fill `phy_list` slot 0 upward, with slot i at bits [5i+4:5i].
- R3: Scanning stops as soon as MAX_PHYS transceivers have been accepted. `phy_count` never exceeds MAX_PHYS.
- R4: For each accepted address, register 0 is read and then register 4. If bits 8:5 of register 4 are all zero, register 1 is read again and the value used is ((status >> 6) & 0x03E0) | 1.
- R5: The advertisement is chosen in this order: the host value if nonzero, else the stored value of the slot if nonzero, else the value found under R4. The chosen value is stored in the slot when the host value is nonzero or the slot is zero. Register 4 is written only when the chosen value differs from the value found.
- R6: In autonegotiation mode (`force_media`=0), control bit 12 is set, and bit 9 is also set if bit 12 was clear. In forced mode, bit 12 is cleared. Then bits 15, 14, 13, 11, 10, 8 and 7 are cleared, bit 8 is set when `full_duplex`=1, and bit 13 is set when `speed_100`=1.
- R7: Register 0 is written only when the new value differs from the value read. When bit 12 changed state, the same value is written twice, with exactly CLK_HZ/1e6·SETTLE_US idle clock cycles between the acknowledge of the first write and the request of the second.
- R8: `scan_done` is low from the cycle after start until the scan ends, then stays high with no request until the next start. A start pulse while a scan is running is ignored. A request's fields stay stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (one-cycle pulse) |
| host_adv | input | 16 | Desired advertisement, 0 = take from PHY |
| force_media | input | 1 | 1 = forced media, 0 = autonegotiation |
| full_duplex | input | 1 | Request full duplex in control register |
| speed_100 | input | 1 | Request 100 Mb/s in control register |
| mdio_req | output | 1 | Management request valid |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Target PHY address |
| mdio_reg | output | 5 | Target register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Request completed (one-cycle pulse) |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| phy_list | output | MAX_PHYS*5 | Found addresses, slot i at [5i+4:5i] |
| phy_count | output | $clog2(MAX_PHYS+1) | Number of PHYs found |
| scan_done | output | 1 | Scan finished |

## Verification
Two functions can meet in the same cycle: a start pulse arriving while a scan is running, and the acceptance of the last free table slot, which both fills the table and ends the scan. The bench pulses start in the middle of a scan and checks that the transaction stream carries on unchanged, without restarting. It also loads a scenario with more transceivers than slots and checks that probing stops right after the slot that fills the table. The checks compare every acknowledged transaction against a queue computed behaviourally from the requirements.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROBE,
      ST_RD_CTRL,
      ST_RD_ADV,
      ST_RD_STAT2,
      ST_DECIDE,
      ST_WR_ADV,
      ST_WR_CTRL1,
      ST_WAIT,
      ST_WR_CTRL2,
      ST_NEXT
   } scan_state_t;

   localparam logic [4:0]  REG_CTRL        = 5'd0;
   localparam logic [4:0]  REG_STAT        = 5'd1;
   localparam logic [4:0]  REG_ADV         = 5'd4;
   localparam logic [15:0] ADV_TECH_MASK   = 16'h01E0;
   localparam logic [15:0] CTRL_AN_EN      = 16'h1000;
   localparam logic [15:0] CTRL_AN_RESTART = 16'h0200;
   localparam logic [15:0] CTRL_DUPLEX     = 16'h0100;
   localparam logic [15:0] CTRL_SPEED      = 16'h2000;
   localparam logic [15:0] CTRL_SCRUB      = 16'hED80;

   function automatic logic [15:0] adv_from_status(input logic [15:0] st);
      return ((st >> 6) & 16'h03E0) | 16'h0001;
   endfunction

endpackage

// File: rtl/phy_accept.sv
module phy_accept (
   input  logic [15:0] status,
   output logic        is_phy
);
   always_comb begin
      is_phy = ((status & 16'h8301) == 16'h8001) ||
               (!status[15] && ((status & 16'h7800) != 16'h0000));
   end
endmodule

// File: rtl/adv_pick.sv
module adv_pick (
   input  logic [15:0] adv_seen,
   input  logic [15:0] host_adv,
   input  logic [15:0] slot_adv,
   output logic [15:0] adv_chosen,
   output logic        slot_store,
   output logic        adv_write
);
   always_comb begin
      if (host_adv != 16'h0)      adv_chosen = host_adv;
      else if (slot_adv != 16'h0) adv_chosen = slot_adv;
      else                        adv_chosen = adv_seen;
      slot_store = (host_adv != 16'h0) || (slot_adv == 16'h0);
      adv_write  = (adv_chosen != adv_seen);
   end
endmodule

// File: rtl/ctrl_calc.sv
module ctrl_calc
   import phy_scan_pkg::*;
(
   input  logic [15:0] ctrl_rd,
   input  logic        force_media,
   input  logic        full_duplex,
   input  logic        speed_100,
   output logic [15:0] ctrl_new,
   output logic        an_toggle,
   output logic        ctrl_write
);
   logic [15:0] work;

   always_comb begin
      if (!force_media) begin
         work      = ctrl_rd | CTRL_AN_EN;
         an_toggle = (work != ctrl_rd);
         if (an_toggle) work = work | CTRL_AN_RESTART;
      end else begin
         work      = ctrl_rd & ~CTRL_AN_EN;
         an_toggle = (work != ctrl_rd);
      end
      work = work & ~CTRL_SCRUB;
      if (full_duplex) work = work | CTRL_DUPLEX;
      if (speed_100)   work = work | CTRL_SPEED;
      ctrl_new   = work;
      ctrl_write = (work != ctrl_rd);
   end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int WAIT_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic expired
);
   initial begin
      if (WAIT_CYC < 1) $error("settle_timer: WAIT_CYC must be at least 1");
   end

   generate
      if (WAIT_CYC <= 1) begin : g_single
         logic armed;
         always_ff @(posedge clk) begin
            if (!rst_n) armed <= 1'b0;
            else        armed <= kick;
         end
         assign expired = armed;
      end else begin : g_count
         localparam int CW = $clog2(WAIT_CYC);
         localparam logic [CW-1:0] LOAD = CW'(WAIT_CYC - 1);
         logic [CW-1:0] cnt;
         logic          busy;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt  <= '0;
               busy <= 1'b0;
            end else if (kick) begin
               cnt  <= LOAD;
               busy <= 1'b1;
            end else if (busy) begin
               if (cnt == '0) busy <= 1'b0;
               else           cnt  <= cnt - 1'b1;
            end
         end
         assign expired = busy && (cnt == '0);

         // R7: the wait counts down one step per cycle
         p_timer_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            busy && (cnt != '0) && !kick |=> busy && (cnt == $past(cnt) - 1'b1));
      end
   endgenerate
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
   import phy_scan_pkg::*;
#(
   parameter int MAX_PHYS  = 4,
   parameter int CLK_HZ    = 50_000_000,
   parameter int SETTLE_US = 10,
   localparam int CNT_W    = $clog2(MAX_PHYS + 1),
   localparam int LIST_W   = MAX_PHYS * 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       host_adv,
   input  logic              force_media,
   input  logic              full_duplex,
   input  logic              speed_100,
   output logic              mdio_req,
   output logic              mdio_wr,
   output logic [4:0]        mdio_phy,
   output logic [4:0]        mdio_reg,
   output logic [15:0]       mdio_wdata,
   input  logic              mdio_ack,
   input  logic [15:0]       mdio_rdata,
   output logic [LIST_W-1:0] phy_list,
   output logic [CNT_W-1:0]  phy_count,
   output logic              scan_done
);
   localparam int SLOT_W   = (MAX_PHYS > 1) ? $clog2(MAX_PHYS) : 1;
   localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_PHYS);

   initial begin
      if (MAX_PHYS < 1 || MAX_PHYS > 32) $error("phy_scan_seq: MAX_PHYS out of 1..32");
      if (WAIT_CYC < 1) $error("phy_scan_seq: settle wait rounds to zero cycles");
   end

   scan_state_t       state;
   logic [5:0]        probe_idx;
   logic [CNT_W-1:0]  count;
   logic [SLOT_W-1:0] cur_slot;
   logic [4:0]        list_q [MAX_PHYS];
   logic [15:0]       slot_adv [MAX_PHYS];
   logic [15:0]       ctrl_q, adv_q;
   logic [15:0]       cfg_host;
   logic              cfg_force, cfg_fd, cfg_100;
   logic              done_q;

   logic              rd_is_phy;
   logic [15:0]       adv_chosen, ctrl_new;
   logic              slot_store, adv_write, an_toggle, ctrl_write;
   logic              timer_kick, timer_expired;

   phy_accept u_accept (.status(mdio_rdata), .is_phy(rd_is_phy));

   adv_pick u_adv (
      .adv_seen(adv_q), .host_adv(cfg_host), .slot_adv(slot_adv[cur_slot]),
      .adv_chosen(adv_chosen), .slot_store(slot_store), .adv_write(adv_write));

   ctrl_calc u_ctrl (
      .ctrl_rd(ctrl_q), .force_media(cfg_force), .full_duplex(cfg_fd),
      .speed_100(cfg_100), .ctrl_new(ctrl_new), .an_toggle(an_toggle),
      .ctrl_write(ctrl_write));

   assign timer_kick = (state == ST_WR_CTRL1) && mdio_ack && an_toggle;

   settle_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .kick(timer_kick), .expired(timer_expired));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         probe_idx <= '0;
         count     <= '0;
         cur_slot  <= '0;
         ctrl_q    <= '0;
         adv_q     <= '0;
         cfg_host  <= '0;
         cfg_force <= 1'b0;
         cfg_fd    <= 1'b0;
         cfg_100   <= 1'b0;
         done_q    <= 1'b0;
         for (int i = 0; i < MAX_PHYS; i++) begin
            list_q[i]   <= '0;
            slot_adv[i] <= '0;
         end
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               probe_idx <= 6'd1;
               count     <= '0;
               done_q    <= 1'b0;
               cfg_host  <= host_adv;
               cfg_force <= force_media;
               cfg_fd    <= full_duplex;
               cfg_100   <= speed_100;
               state     <= ST_PROBE;
            end
            ST_PROBE: if (mdio_ack) begin
               if (rd_is_phy) begin
                  list_q[count[SLOT_W-1:0]] <= probe_idx[4:0];
                  cur_slot <= count[SLOT_W-1:0];
                  count    <= count + 1'b1;
                  state    <= ST_RD_CTRL;
               end else begin
                  state <= ST_NEXT;
               end
            end
            ST_RD_CTRL: if (mdio_ack) begin
               ctrl_q <= mdio_rdata;
               state  <= ST_RD_ADV;
            end
            ST_RD_ADV: if (mdio_ack) begin
               if ((mdio_rdata & ADV_TECH_MASK) == 16'h0) begin
                  state <= ST_RD_STAT2;
               end else begin
                  adv_q <= mdio_rdata;
                  state <= ST_DECIDE;
               end
            end
            ST_RD_STAT2: if (mdio_ack) begin
               adv_q <= adv_from_status(mdio_rdata);
               state <= ST_DECIDE;
            end
            ST_DECIDE: begin
               if (slot_store) slot_adv[cur_slot] <= adv_chosen;
               if (adv_write)       state <= ST_WR_ADV;
               else if (ctrl_write) state <= ST_WR_CTRL1;
               else                 state <= ST_NEXT;
            end
            ST_WR_ADV: if (mdio_ack) state <= ctrl_write ? ST_WR_CTRL1 : ST_NEXT;
            ST_WR_CTRL1: if (mdio_ack) state <= an_toggle ? ST_WAIT : ST_NEXT;
            ST_WAIT: if (timer_expired) state <= ST_WR_CTRL2;
            ST_WR_CTRL2: if (mdio_ack) state <= ST_NEXT;
            ST_NEXT: begin
               if (probe_idx == 6'd32 || count == FULL) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  probe_idx <= probe_idx + 1'b1;
                  state     <= ST_PROBE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mdio_req   = 1'b0;
      mdio_wr    = 1'b0;
      mdio_reg   = REG_STAT;
      mdio_wdata = 16'h0000;
      unique case (state)
         ST_PROBE, ST_RD_STAT2: mdio_req = 1'b1;
         ST_RD_CTRL: begin mdio_req = 1'b1; mdio_reg = REG_CTRL; end
         ST_RD_ADV:  begin mdio_req = 1'b1; mdio_reg = REG_ADV;  end
         ST_WR_ADV: begin
            mdio_req = 1'b1; mdio_wr = 1'b1; mdio_reg = REG_ADV; mdio_wdata = adv_chosen;
         end
         ST_WR_CTRL1, ST_WR_CTRL2: begin
            mdio_req = 1'b1; mdio_wr = 1'b1; mdio_reg = REG_CTRL; mdio_wdata = ctrl_new;
         end
         default: ;
      endcase
   end

   assign mdio_phy  = probe_idx[4:0];
   assign phy_count = count;
   assign scan_done = done_q;

   generate
      for (genvar g = 0; g < MAX_PHYS; g++) begin : g_list
         assign phy_list[g*5 +: 5] = list_q[g];
      end
   endgenerate

   // R8: request fields held until acknowledged
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_phy) && $stable(mdio_reg)
                                && $stable(mdio_wr) && $stable(mdio_wdata));
   // R8: no traffic once the scan has ended
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !mdio_req);
   // R3: table never overfills
   p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phy_count <= FULL);
   // R6: scrubbed control bits never reach the bus
   p_ctrl_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req && mdio_wr && (mdio_reg == REG_CTRL) |-> (mdio_wdata & 16'hCC80) == 16'h0);
   // R5: an advertisement write always changes the value found
   p_adv_differs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req && mdio_wr && (mdio_reg == REG_ADV) |-> mdio_wdata != adv_q);
endmodule

// File: tb/phy_scan_seq_tb.sv
module phy_scan_seq_tb;
   localparam int MAXP  = 4;
   localparam int WAITC = 500;
   localparam int LAT   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [15:0]       host_adv = '0;
   logic              force_media = 1'b0, full_duplex = 1'b0, speed_100 = 1'b0;
   logic              mdio_req, mdio_wr;
   logic [4:0]        mdio_phy, mdio_reg;
   logic [15:0]       mdio_wdata;
   logic              mdio_ack;
   logic [15:0]       mdio_rdata;
   logic [MAXP*5-1:0] phy_list;
   logic [2:0]        phy_count;
   logic              scan_done;

   always #10 clk = ~clk;

   phy_scan_seq #(.MAX_PHYS(MAXP), .CLK_HZ(50_000_000), .SETTLE_US(10)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .host_adv(host_adv),
      .force_media(force_media), .full_duplex(full_duplex), .speed_100(speed_100),
      .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
      .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
      .phy_list(phy_list), .phy_count(phy_count), .scan_done(scan_done));

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // transceiver register model, owned by the responder process
   logic [15:0] m_stat [32];
   logic [15:0] m_ctrl [32];
   logic [15:0] m_adv  [32];
   int          load_sel = 0;
   logic        load_go = 1'b0;
   int          lat;

   always @(posedge clk) begin
      if (load_go) begin
         for (int a = 0; a < 32; a++) begin
            m_stat[a] <= 16'hFFFF; m_ctrl[a] <= 16'hFFFF; m_adv[a] <= 16'hFFFF;
         end
         if (load_sel == 1) begin
            m_stat[3]  <= 16'h7849; m_ctrl[3]  <= 16'h0000; m_adv[3]  <= 16'h01E1;
            m_stat[9]  <= 16'h7809; m_ctrl[9]  <= 16'h1000; m_adv[9]  <= 16'h0061;
            m_stat[0]  <= 16'h8001; m_ctrl[0]  <= 16'h3D00; m_adv[0]  <= 16'h0000;
            m_stat[12] <= 16'h8101;
            m_stat[20] <= 16'hF800;
         end else begin
            for (int a = 1; a < 8; a++) begin
               if (a != 3 && a != 4) begin
                  m_stat[a] <= 16'h7809; m_ctrl[a] <= 16'h1000; m_adv[a] <= 16'h01E1;
               end
            end
         end
      end
      if (!rst_n) begin
         mdio_ack <= 1'b0; mdio_rdata <= 16'h0; lat <= 0;
      end else begin
         mdio_ack <= 1'b0;
         if (mdio_req && !mdio_ack) begin
            if (lat == LAT) begin
               lat <= 0;
               mdio_ack <= 1'b1;
               if (mdio_wr) begin
                  if (mdio_reg == 5'd0)      m_ctrl[mdio_phy] <= mdio_wdata;
                  else if (mdio_reg == 5'd4) m_adv[mdio_phy]  <= mdio_wdata;
               end else begin
                  case (mdio_reg)
                     5'd0:    mdio_rdata <= m_ctrl[mdio_phy];
                     5'd1:    mdio_rdata <= m_stat[mdio_phy];
                     5'd4:    mdio_rdata <= m_adv[mdio_phy];
                     default: mdio_rdata <= 16'hFFFF;
                  endcase
               end
            end else begin
               lat <= lat + 1;
            end
         end
      end
   end

   // behavioural reference: expected transaction stream {wr, phy, reg, data}
   logic [26:0] exp_q [$];
   logic [15:0] tb_slot [MAXP];
   logic [4:0]  exp_list [MAXP];
   int          exp_count;

   task automatic build_exp(input logic [15:0] host, input bit frc, input bit fd,
                            input bit s100);
      int cnt = 0;
      exp_q.delete();
      for (int n = 1; n <= 32 && cnt < MAXP; n++) begin
         logic [4:0]  a;
         logic [15:0] st, r0, ad, ch, nb;
         bit          tg;
         a  = 5'(n);
         st = m_stat[a];
         exp_q.push_back({1'b0, a, 5'd1, 16'h0});
         if (!(((st & 16'h8301) == 16'h8001) || (!st[15] && (st & 16'h7800) != 0))) continue;
         exp_q.push_back({1'b0, a, 5'd0, 16'h0});
         exp_q.push_back({1'b0, a, 5'd4, 16'h0});
         r0 = m_ctrl[a];
         ad = m_adv[a];
         if ((ad & 16'h01E0) == 0) begin
            exp_q.push_back({1'b0, a, 5'd1, 16'h0});
            ad = ((st >> 6) & 16'h03E0) | 16'h0001;
         end
         if (host != 0) begin ch = host; tb_slot[cnt] = host; end
         else if (tb_slot[cnt] != 0) ch = tb_slot[cnt];
         else begin ch = ad; tb_slot[cnt] = ad; end
         if (ch != ad) exp_q.push_back({1'b1, a, 5'd4, ch});
         if (!frc) begin
            nb = r0 | 16'h1000; tg = (nb != r0);
            if (tg) nb = nb | 16'h0200;
         end else begin
            nb = r0 & ~16'h1000; tg = (nb != r0);
         end
         nb = nb & ~16'hED80;
         if (fd)   nb = nb | 16'h0100;
         if (s100) nb = nb | 16'h2000;
         if (nb != r0) begin
            exp_q.push_back({1'b1, a, 5'd0, nb});
            if (tg) exp_q.push_back({1'b1, a, 5'd0, nb});
         end
         exp_list[cnt] = a;
         cnt++;
      end
      exp_count = cnt;
   endtask

   function automatic string tag_of(input logic [26:0] t);
      if (t[26] && t[20:16] == 5'd4) return "R5 adv write";
      if (t[26])                     return "R6 ctrl write";
      if (t[20:16] == 5'd1)          return "R1 status read";
      return "R4 register read";
   endfunction

   // per-clock comparison of acknowledged transactions
   int          gap = 0;
   logic [26:0] prev_t = '0;
   always @(negedge clk) begin
      if (rst_n && mdio_req && mdio_ack) begin
         logic [26:0] got, e;
         got = {mdio_wr, mdio_phy, mdio_reg, mdio_wdata};
         if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected transaction", 32'(got), 32'h0);
         end else begin
            e = exp_q.pop_front();
            if (e[26]) check(got == e, tag_of(e), 32'(got), 32'(e));
            else       check(got[26:16] == e[26:16], tag_of(e), 32'(got[26:16]), 32'(e[26:16]));
         end
         if (got[26] && got[20:16] == 5'd0 && prev_t == got)
            check(gap == WAITC, "R7 settle gap", 32'(gap), 32'(WAITC));
         prev_t = got;
         gap = 0;
      end else if (!mdio_req) begin
         gap++;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic load_model(input int sel);
      @(negedge clk); load_sel = sel; load_go = 1'b1;
      @(negedge clk); load_go = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_scan(input logic [15:0] host, input bit frc, input bit fd,
                           input bit s100, input bit poke);
      build_exp(host, frc, fd, s100);
      @(negedge clk);
      host_adv = host; force_media = frc; full_duplex = fd; speed_100 = s100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(scan_done == 1'b0, "R8 done low while busy", 32'(scan_done), 32'h0);
      if (poke) begin
         repeat (40) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!scan_done) @(negedge clk);
      check(exp_q.size() == 0, "R1 all expected transactions seen", 32'(exp_q.size()), 32'h0);
      check(phy_count == 3'(exp_count), "R3 phy count", 32'(phy_count), 32'(exp_count));
      for (int i = 0; i < exp_count; i++)
         check(phy_list[i*5 +: 5] == exp_list[i], "R2 address table",
               32'(phy_list[i*5 +: 5]), 32'(exp_list[i]));
      repeat (5) @(negedge clk);
      check(scan_done && !mdio_req, "R8 done held and bus quiet",
            {30'h0, scan_done, mdio_req}, 32'h2);
   endtask

   initial begin
      for (int i = 0; i < MAXP; i++) tb_slot[i] = 16'h0;
      repeat (3) @(negedge clk);
      load_model(1);
      rst_n = 1'b1;
      @(negedge clk);
      check(scan_done == 1'b0, "R8 reset done", 32'(scan_done), 32'h0);
      check(phy_count == 3'd0, "R3 reset count", 32'(phy_count), 32'h0);
      check(mdio_req == 1'b0, "R8 reset request", 32'(mdio_req), 32'h0);
      // autonegotiation, fallback advertisement, double control write
      run_scan(16'h0000, 1'b0, 1'b1, 1'b1, 1'b0);
      // forced media with a host advertisement
      run_scan(16'h05E1, 1'b1, 1'b0, 1'b0, 1'b0);
      // stored slot value wins; start pulse mid-scan is ignored
      run_scan(16'h0000, 1'b0, 1'b1, 1'b0, 1'b1);
      // more transceivers than slots: early stop
      load_model(2);
      run_scan(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule